// File: doc/BRIEF.md
# Phase-Frequency Detector With Lock Detect

This block compares two pulse trains inside a frequency synthesizer: a reference pulse and a pulse from the feedback divider. Both are synchronous to the reference-oscillator clock, and the block measures the time between their rising edges in oscillator cycles. While one edge has arrived and the other has not, the block asks the charge pump to drive. A polarity input picks whether a leading reference drives the pump high or low. When the phases match, the pump stays in high impedance. Every comparison ends with a one-cycle overlap of the internal up and down requests, which avoids a dead zone around lock.

A lock detector watches the measured error of each comparison. The lock flag rises after a set number of consecutive comparisons with a small error. It falls once a running comparison reaches a larger error threshold, without waiting for the comparison to finish. A monitor output shows either the lock flag or one of the two compared pulses. A power-save input turns off the pump, clears the comparison and holds the lock flag high. After power save ends, the first correction pulse is cut to one cycle so that the loop does not take a large step.

Top module: `phase_cmp_lockdet`

## Requirements
- R1: After reset the pump command is high impedance (`cp_en_o`=0), `up_o`, `dn_o` and `lock_o` are 0.
- R2: With `pol_i`=1, a reference edge k cycles ahead of the divider edge drives the pump for exactly k cycles with `cp_lvl_o`=1. A divider edge k cycles ahead drives it for k cycles with `cp_lvl_o`=0.
- R3: With `pol_i`=0, the pump levels of R2 are inverted and the drive lengths stay the same.
- R4: Edges on both inputs in the same cycle give no pump drive: the pump stays at high impedance.
- R5: Every completed comparison, matched ones included, ends with exactly one cycle in which `up_o` and `dn_o` are both 1, and the pump is at high impedance in that cycle.
- R6: A second rising edge on the leading input, while its request is still open, neither restarts nor ends the request. The pump drives from the first leading edge until the lagging edge.
- R7: `lock_o` rises after LOCK_CNT (default 3) consecutive comparisons with an error of at most LOCK_TH (default 1) cycles. A comparison with a larger error resets that run.
- R8: Once the error count of a running comparison reaches UNLOCK_TH (default 3) cycles, `lock_o` falls one cycle later, before the lagging edge arrives.
- R9: With `mon_sel_i`=1, `mon_o` follows `ref_i` when `pol_i`=1 and `div_i` when `pol_i`=0. With `mon_sel_i`=0, `mon_o` equals `lock_o`.
- R10: While `save_i`=1, the pump is at high impedance, `up_o` and `dn_o` are 0, `lock_o` is 1, and input edges start no comparison.
- R11: In the first comparison after `save_i` falls, the pump drives for one cycle only. Later comparisons drive for their full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference pulse; the rising edge is used |
| div_i | input | 1 | Divided feedback pulse; the rising edge is used |
| pol_i | input | 1 | Pump polarity: 1 means a leading reference drives high |
| mon_sel_i | input | 1 | Monitor select: 1 shows a compared pulse, 0 shows the lock flag |
| save_i | input | 1 | Power save, active high |
| cp_en_o | output | 1 | Pump drive enable; 0 means high impedance |
| cp_lvl_o | output | 1 | Pump level while driving |
| up_o | output | 1 | Internal reference-leads request |
| dn_o | output | 1 | Internal divider-leads request |
| lock_o | output | 1 | Lock flag, 1 means locked |
| mon_o | output | 1 | Monitor output |

## Verification
The bench goes after the boundary between a lock-keeping error of two cycles and an unlocking error of three, and samples the lock flag in the middle of a long comparison. A design that waited for the comparison to end before unlocking, or that did not clear the good-comparison run after a medium error, would give the wrong flag. It also sends coincident edges and a repeated leading edge. A design that let the pump drive on coincident edges, dropped the overlap cycle, or restarted the count on the repeat would show the wrong drive length. Last, it checks the one-cycle pulse after power save and that full pulses return afterwards. A design whose limit never cleared, or never applied, would fail here.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Three-state pump command
    typedef enum logic [1:0] {
        CP_HIZ  = 2'd0,
        CP_SRC  = 2'd1,
        CP_SINK = 2'd2
    } cp_cmd_e;

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_d, prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_comb begin
            prev_d[g] = sig_i[g];
            rise_o[g] = sig_i[g] & ~prev_q[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_i,
    input  logic             ref_rise_i,
    input  logic             div_rise_i,
    output logic             up_o,
    output logic             dn_o,
    output logic             lead_up_o,
    output logic             drive_o,
    output logic             done_o,
    output logic [ERR_W-1:0] err_o
);

    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    typedef struct packed {
        logic             up;
        logic             dn;
        logic [ERR_W-1:0] err;
        logic             lim;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (save_i) begin
            st_d.up  = 1'b0;
            st_d.dn  = 1'b0;
            st_d.err = '0;
            st_d.lim = 1'b1;
        end else if (st_q.up && st_q.dn) begin
            // overlap cycle: close the comparison
            st_d.up  = 1'b0;
            st_d.dn  = 1'b0;
            st_d.err = '0;
            st_d.lim = 1'b0;
        end else begin
            st_d.up = st_q.up | ref_rise_i;
            st_d.dn = st_q.dn | div_rise_i;
            if ((st_q.up ^ st_q.dn) && (st_q.err != ERR_MAX))
                st_d.err = st_q.err + ERR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        up_o      = st_q.up & ~save_i;
        dn_o      = st_q.dn & ~save_i;
        lead_up_o = st_q.up;
        done_o    = st_q.up & st_q.dn & ~save_i;
        err_o     = st_q.err;
        drive_o   = (st_q.up ^ st_q.dn) & ~save_i &
                    (~st_q.lim | (st_q.err == '0));
    end

    // R5
    overlap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.up && st_q.dn) |=> (!st_q.up && !st_q.dn));

    // R10
    save_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_i |=> (!st_q.up && !st_q.dn));

    // R11
    first_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lim && drive_o) |=> !drive_o);

endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
    parameter int ERR_W     = 8,
    parameter int LOCK_TH   = 1,
    parameter int UNLOCK_TH = 3,
    parameter int LOCK_CNT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_i,
    input  logic             done_i,
    input  logic [ERR_W-1:0] err_i,
    output logic             lock_o
);

    localparam int GW = $clog2(LOCK_CNT + 1);
    localparam logic [ERR_W-1:0] LOCK_LIM   = ERR_W'(LOCK_TH);
    localparam logic [ERR_W-1:0] UNLOCK_LIM = ERR_W'(UNLOCK_TH);
    localparam logic [GW-1:0]    GOOD_LAST  = GW'(LOCK_CNT - 1);
    localparam logic [GW-1:0]    GOOD_FULL  = GW'(LOCK_CNT);

    typedef struct packed {
        logic          lock;
        logic [GW-1:0] good;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (save_i) begin
            st_d.lock = 1'b1;
            st_d.good = '0;
        end else if (err_i >= UNLOCK_LIM) begin
            st_d.lock = 1'b0;
            st_d.good = '0;
        end else if (done_i) begin
            if (err_i <= LOCK_LIM) begin
                if (st_q.good >= GOOD_LAST) begin
                    st_d.lock = 1'b1;
                    st_d.good = GOOD_FULL;
                end else begin
                    st_d.good = st_q.good + GW'(1);
                end
            end else begin
                st_d.good = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o = st_q.lock | save_i;

    // R8
    unlock_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_i >= UNLOCK_LIM) && !save_i) |=> !st_q.lock);

    // R7
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lock) |-> ($past(save_i) || ($past(st_q.good) == GOOD_LAST)));

endmodule

// File: rtl/pfd_out.sv
module pfd_out
    import pfd_pkg::*;
(
    input  logic pol_i,
    input  logic mon_sel_i,
    input  logic drive_i,
    input  logic lead_up_i,
    input  logic lock_i,
    input  logic ref_i,
    input  logic div_i,
    output logic cp_en_o,
    output logic cp_lvl_o,
    output logic mon_o
);

    cp_cmd_e cmd;

    always_comb begin
        if (!drive_i)
            cmd = CP_HIZ;
        else if (lead_up_i == pol_i)
            cmd = CP_SRC;
        else
            cmd = CP_SINK;
        cp_en_o  = (cmd != CP_HIZ);
        cp_lvl_o = (cmd == CP_SRC);
        mon_o    = mon_sel_i ? (pol_i ? ref_i : div_i) : lock_i;
    end

endmodule

// File: rtl/phase_cmp_lockdet.sv
module phase_cmp_lockdet #(
    parameter int ERR_W     = 8,
    parameter int LOCK_TH   = 1,
    parameter int UNLOCK_TH = 3,
    parameter int LOCK_CNT  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    input  logic div_i,
    input  logic pol_i,
    input  logic mon_sel_i,
    input  logic save_i,
    output logic cp_en_o,
    output logic cp_lvl_o,
    output logic up_o,
    output logic dn_o,
    output logic lock_o,
    output logic mon_o
);

    logic [1:0]       rise;
    logic             lead_up, drive, done;
    logic [ERR_W-1:0] err;

    pfd_edge #(.N(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  ({div_i, ref_i}),
        .rise_o (rise)
    );

    pfd_core #(.ERR_W(ERR_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .save_i     (save_i),
        .ref_rise_i (rise[0]),
        .div_rise_i (rise[1]),
        .up_o       (up_o),
        .dn_o       (dn_o),
        .lead_up_o  (lead_up),
        .drive_o    (drive),
        .done_o     (done),
        .err_o      (err)
    );

    pfd_lock #(
        .ERR_W     (ERR_W),
        .LOCK_TH   (LOCK_TH),
        .UNLOCK_TH (UNLOCK_TH),
        .LOCK_CNT  (LOCK_CNT)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .save_i (save_i),
        .done_i (done),
        .err_i  (err),
        .lock_o (lock_o)
    );

    pfd_out u_out (
        .pol_i     (pol_i),
        .mon_sel_i (mon_sel_i),
        .drive_i   (drive),
        .lead_up_i (lead_up),
        .lock_i    (lock_o),
        .ref_i     (ref_i),
        .div_i     (div_i),
        .cp_en_o   (cp_en_o),
        .cp_lvl_o  (cp_lvl_o),
        .mon_o     (mon_o)
    );

    // R10
    save_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_i |-> (!cp_en_o && lock_o && !up_o && !dn_o));

    // R5
    overlap_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o && dn_o) |-> !cp_en_o);

endmodule

// File: tb/phase_cmp_lockdet_tb.sv
module phase_cmp_lockdet_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_i = 1'b0, div_i = 1'b0, pol_i = 1'b1, mon_sel_i = 1'b0, save_i = 1'b0;
    logic cp_en_o, cp_lvl_o, up_o, dn_o, lock_o, mon_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    phase_cmp_lockdet u_dut (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .div_i(div_i), .pol_i(pol_i),
        .mon_sel_i(mon_sel_i), .save_i(save_i), .cp_en_o(cp_en_o),
        .cp_lvl_o(cp_lvl_o), .up_o(up_o), .dn_o(dn_o), .lock_o(lock_o), .mon_o(mon_o)
    );

    // columns: polarity, reference edge index, divider edge index
    localparam int NVEC = 8;
    localparam int VEC [NVEC][3] = '{
        '{1, 0, 3}, '{1, 3, 0}, '{1, 0, 0}, '{1, 0, 1},
        '{1, 2, 9}, '{0, 0, 3}, '{0, 4, 0}, '{0, 0, 0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One comparison: single-cycle pulses applied at given cycle indices (-1 = none)
    task automatic run_pair(input int ra, input int da, input int r2, input int probe,
                            output int nhi, output int nlo, output int nboth,
                            output logic lk_probe);
        int w;
        w = (ra > da ? ra : da);
        if (r2 > w) w = r2;
        w = w + 5;
        nhi = 0; nlo = 0; nboth = 0; lk_probe = lock_o;
        for (int i = 0; i <= w; i++) begin
            @(negedge clk);
            if (i > 0) begin
                if (cp_en_o && cp_lvl_o)  nhi++;
                if (cp_en_o && !cp_lvl_o) nlo++;
                if (up_o && dn_o)         nboth++;
                if (i == probe)           lk_probe = lock_o;
            end
            ref_i = (i == ra) || (i == r2);
            div_i = (i == da);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_i = 1'b0; div_i = 1'b0; save_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int hi, lo, both, lead, mag, exp_hi, exp_lo;
        logic lk;

        do_reset();
        // R1 reset state
        check("R1 cp_en", int'(cp_en_o), 0);
        check("R1 lock", int'(lock_o), 0);
        check("R1 up/dn", int'(up_o | dn_o), 0);

        // table walk: R2, R3, R4, R5
        for (int v = 0; v < NVEC; v++) begin
            pol_i = VEC[v][0][0];
            run_pair(VEC[v][1], VEC[v][2], -1, -1, hi, lo, both, lk);
            lead = VEC[v][2] - VEC[v][1];
            mag  = lead < 0 ? -lead : lead;
            exp_hi = 0; exp_lo = 0;
            if (lead != 0) begin
                if ((lead > 0) == (VEC[v][0] == 1)) exp_hi = mag;
                else                                 exp_lo = mag;
            end
            if (lead == 0) begin
                check("R4 no drive", hi + lo, 0);
            end else if (VEC[v][0] == 1) begin
                check("R2 high cycles", hi, exp_hi);
                check("R2 low cycles", lo, exp_lo);
            end else begin
                check("R3 high cycles", hi, exp_hi);
                check("R3 low cycles", lo, exp_lo);
            end
            check("R5 overlap cycles", both, 1);
        end

        // R6 repeated leading edge
        pol_i = 1'b1;
        run_pair(0, 6, 3, -1, hi, lo, both, lk);
        check("R6 drive length", hi, 6);
        check("R6 overlap", both, 1);

        // R9 monitor of compared pulses
        mon_sel_i = 1'b1; pol_i = 1'b1;
        @(negedge clk); ref_i = 1'b1; div_i = 1'b0; #1;
        check("R9 mon ref high", int'(mon_o), 1);
        @(negedge clk); ref_i = 1'b0; div_i = 1'b1; #1;
        check("R9 mon ref low", int'(mon_o), 0);
        pol_i = 1'b0; #1;
        check("R9 mon div high", int'(mon_o), 1);
        @(negedge clk); ref_i = 1'b1; div_i = 1'b0; #1;
        check("R9 mon div low", int'(mon_o), 0);
        @(negedge clk); ref_i = 1'b0;
        mon_sel_i = 1'b0; pol_i = 1'b1;

        // R7 lock acquisition with run reset
        do_reset();
        run_pair(0, 1, -1, -1, hi, lo, both, lk);
        run_pair(0, 1, -1, -1, hi, lo, both, lk);
        run_pair(0, 2, -1, -1, hi, lo, both, lk);
        run_pair(0, 1, -1, -1, hi, lo, both, lk);
        run_pair(0, 1, -1, -1, hi, lo, both, lk);
        check("R7 not locked after broken run", int'(lock_o), 0);
        run_pair(0, 1, -1, -1, hi, lo, both, lk);
        check("R7 locked after three good", int'(lock_o), 1);
        check("R9 mon shows lock", int'(mon_o), 1);

        // R8 unlock threshold
        run_pair(0, 2, -1, -1, hi, lo, both, lk);
        check("R8 two-cycle error keeps lock", int'(lock_o), 1);
        run_pair(0, 6, -1, 5, hi, lo, both, lk);
        check("R8 lock dropped mid comparison", int'(lk), 0);
        check("R8 drive length", hi, 6);

        // R10 power save
        @(negedge clk); save_i = 1'b1; #1;
        check("R10 cp hiz", int'(cp_en_o), 0);
        check("R10 lock high", int'(lock_o), 1);
        run_pair(0, 3, -1, -1, hi, lo, both, lk);
        check("R10 no drive", hi + lo, 0);
        check("R10 no requests", both, 0);
        check("R10 up/dn low", int'(up_o | dn_o), 0);

        // R11 limited first pulse
        @(negedge clk); save_i = 1'b0;
        repeat (2) @(negedge clk);
        run_pair(0, 5, -1, -1, hi, lo, both, lk);
        check("R11 first pulse one cycle", hi, 1);
        run_pair(0, 5, -1, -1, hi, lo, both, lk);
        check("R11 full pulse after", hi, 5);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule